// File: doc/BRIEF.md
# SPI Write Command Front End

This block is the receive side of a serial memory slave for a single job: taking in a memory write over an SPI link (mode 0, most significant bit first) and deciding whether the write may go ahead. A transaction opens when chip select falls. The block then shifts in an opcode byte, a two-byte address and any number of data bytes, all on the serial data input. For each complete data byte it presents the byte and its target address to a downstream page buffer. The target address moves through one page and wraps back to the start of that page when it passes the last byte.

The decision is made only when chip select rises. At that edge the block issues either a one-cycle `commit` pulse, so the page buffer starts its self-timed write, or a one-cycle `abort` pulse, so the buffer throws away what it has collected. Four conditions must all hold for a commit:
- the transaction stopped exactly after the last bit of at least one full data byte;
- the write enable latch is set;
- the downstream write-in-progress flag is low;
- the addressed page is outside the protected region.

A small status model holds the write enable latch and the two protection bits, and it reads write-in-progress as an input. The serial output is never driven during this command.

Top module: `spi_wr_front`

## Requirements
- R1: When opcode 8'h02 is followed by the 16-bit address and N complete data bytes, exactly N pulses appear on `byte_valid`, and `byte_data` carries the bytes in the order they were sent, each one shifted in MSB first on rising SCK edges.
- R2: The first data byte goes to the received address. Each later byte goes to the next address, with the 5-bit in-page offset (`byte_addr[4:0]`) wrapping from 31 to 0 while the page bits `byte_addr[10:5]` stay the same.
- R3: If the write enable latch is clear when chip select rises, the write is aborted.
- R4: If `wip_in` is high in the cycle where the chip-select rise is seen, the write is aborted.
- R5: With protection code `bp` equal to 2'b00 no page is protected, 2'b01 protects pages 48..63, 2'b10 protects pages 32..63 and 2'b11 protects every page. A write to a protected page is aborted.
- R6: A write is aborted if chip select rises anywhere other than right after bit 0 of a data byte. This includes a rise during the address bytes and a rise before any data byte has arrived.
- R7: Address bits 15..11 have no effect on the emitted address or on the protection decision.
- R8: Any opcode other than 8'h02 causes the rest of the transaction to be ignored: no `byte_valid`, no `commit`, no `abort`, and the write enable latch keeps its value.
- R9: `wel_set` sets the write enable latch. The latch is cleared on the cycle of the `commit` or `abort` pulse that ends each write attempt.
- R10: `so_oe` stays low at all times, so the serial output remains high impedance.
- R11: Each write attempt produces exactly one one-cycle pulse, on either `commit` or `abort` and never on both.
- R12: A `bp_load` pulse copies `bp_din` into `bp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data input |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Serial output enable; 0 means high impedance |
| wel_set | input | 1 | Sets the write enable latch |
| bp_load | input | 1 | Loads the protection bits from bp_din |
| bp_din | input | 2 | New protection code |
| wip_in | input | 1 | Write-in-progress flag from the page buffer |
| byte_valid | output | 1 | One-cycle strobe for a received data byte |
| byte_addr | output | 11 | Array address of that byte |
| byte_data | output | 8 | Data byte |
| commit | output | 1 | One-cycle pulse: accepted write, start the cycle |
| abort | output | 1 | One-cycle pulse: rejected write, discard the bytes |
| wel | output | 1 | Current write enable latch |
| bp | output | 2 | Current protection code |

## Verification
The hardest case to reach from the ports is a chip-select rise that is off a byte boundary. This needs a transaction cut off after a chosen number of bits inside a data byte, or inside the second address byte. The bench reaches it with a bit-granular shift task that can stop mid-byte before it raises chip select. It also runs a sweep of all four protection codes over all 64 pages, with random-looking upper address bits. A 35-byte burst covers the in-page offset wrap. Each rejection cause is applied alone, with the other three conditions held favourable, so that each cause shows up on its own.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } wr_state_t;

  localparam logic [7:0] OPC_WRITE = 8'h02;

  // top2: two most significant page bits
  function automatic logic page_locked(input logic [1:0] code, input logic [1:0] top2);
    case (code)
      2'b00:   page_locked = 1'b0;
      2'b01:   page_locked = top2[1] & top2[0];
      2'b10:   page_locked = top2[1];
      default: page_locked = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_fall
);

  // bit 0: cs_n, bit 1: sck, bit 2: mosi
  localparam logic [2:0] IDLE_VAL = 3'b001;

  logic [2:0] pipe [STAGES];
  logic [1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe[g] <= IDLE_VAL;
      end else begin
        if (g == 0) pipe[g] <= {mosi, sck, cs_n};
        else        pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b01;
    else     prev_q <= pipe[STAGES-1][1:0];
  end

  assign cs_n_s   = pipe[STAGES-1][0];
  assign mosi_s   = pipe[STAGES-1][2];
  assign sck_rise = pipe[STAGES-1][1] & ~prev_q[1];
  assign cs_rise  = pipe[STAGES-1][0] & ~prev_q[0];
  assign cs_fall  = ~pipe[STAGES-1][0] & prev_q[0];

endmodule

// File: rtl/spi_wr_shift.sv
module spi_wr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              at_bound
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        sh_q  <= {sh_q[BYTE_W-3:0], mosi_s};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          byte_done <= 1'b1;
          byte_val  <= {sh_q, mosi_s};
        end
      end
    end
  end

  assign at_bound = (cnt_q == '0);

endmodule

// File: rtl/spi_wr_status.sv
module spi_wr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       bp_load,
  input  logic [1:0] bp_din,
  output logic       wel,
  output logic [1:0] bp
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
      bp  <= 2'b00;
    end else begin
      if (wel_clr)      wel <= 1'b0;
      else if (wel_set) wel <= 1'b1;
      if (bp_load) bp <= bp_din;
    end
  end

endmodule

// File: rtl/spi_wr_ctrl.sv
module spi_wr_ctrl
  import spi_wr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic              at_bound,
  input  logic              wel,
  input  logic              wip,
  input  logic [1:0]        bp,
  output logic              wel_clr,
  output logic              byte_valid,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              commit,
  output logic              abort
);

  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int LO_PG = 8 - PAGE_W;

  wr_state_t         st_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              have_data_q;
  logic              attempt_q;
  logic              accept;

  assign accept = (st_q == ST_DATA) && have_data_q && at_bound && wel && !wip
                  && !page_locked(bp, page_q[PG_W-1 -: 2]);
  assign wel_clr = cs_rise && attempt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      page_q      <= '0;
      off_q       <= '0;
      have_data_q <= 1'b0;
      attempt_q   <= 1'b0;
      byte_valid  <= 1'b0;
      byte_addr   <= '0;
      byte_data   <= '0;
      commit      <= 1'b0;
      abort       <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      commit     <= 1'b0;
      abort      <= 1'b0;
      if (byte_done) begin
        case (st_q)
          ST_OPC: begin
            if (byte_val == OPC_WRITE) begin
              st_q      <= ST_AHI;
              attempt_q <= 1'b1;
            end else begin
              st_q <= ST_SKIP;
            end
          end
          ST_AHI: begin
            page_q[PG_W-1:LO_PG] <= byte_val[HI_W-1:0];
            st_q <= ST_ALO;
          end
          ST_ALO: begin
            page_q[LO_PG-1:0] <= byte_val[7:PAGE_W];
            off_q <= byte_val[PAGE_W-1:0];
            st_q  <= ST_DATA;
          end
          ST_DATA: begin
            byte_valid  <= 1'b1;
            byte_addr   <= {page_q, off_q};
            byte_data   <= byte_val;
            off_q       <= off_q + 1'b1;
            have_data_q <= 1'b1;
          end
          default: ;
        endcase
      end
      if (cs_fall) begin
        st_q        <= ST_OPC;
        have_data_q <= 1'b0;
        attempt_q   <= 1'b0;
      end
      if (cs_rise) begin
        st_q        <= ST_IDLE;
        attempt_q   <= 1'b0;
        have_data_q <= 1'b0;
        if (attempt_q) begin
          commit <= accept;
          abort  <= !accept;
        end
      end
    end
  end

endmodule

// File: rtl/spi_wr_front.sv
module spi_wr_front #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              so,
  output logic              so_oe,
  input  logic              wel_set,
  input  logic              bp_load,
  input  logic [1:0]        bp_din,
  input  logic              wip_in,
  output logic              byte_valid,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              commit,
  output logic              abort,
  output logic              wel,
  output logic [1:0]        bp
);

  logic       cs_n_s, mosi_s, sck_rise, cs_rise, cs_fall;
  logic       byte_done, at_bound, wel_clr;
  logic [7:0] byte_val;

  spi_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sck_rise(sck_rise),
    .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  spi_wr_shift #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .byte_done(byte_done), .byte_val(byte_val),
    .at_bound(at_bound)
  );

  spi_wr_status u_status (
    .clk(clk), .rst(rst), .wel_set(wel_set), .wel_clr(wel_clr),
    .bp_load(bp_load), .bp_din(bp_din), .wel(wel), .bp(bp)
  );

  spi_wr_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .byte_done(byte_done), .byte_val(byte_val), .at_bound(at_bound),
    .wel(wel), .wip(wip_in), .bp(bp), .wel_clr(wel_clr),
    .byte_valid(byte_valid), .byte_addr(byte_addr), .byte_data(byte_data),
    .commit(commit), .abort(abort)
  );

  // Output pin stays released for the whole write command.
  always_ff @(posedge clk) begin
    so    <= 1'b0;
    so_oe <= 1'b0;
  end

endmodule

// File: rtl/spi_wr_front_chk.sv
module spi_wr_front_chk (
  input logic clk,
  input logic rst,
  input logic commit,
  input logic abort,
  input logic wel,
  input logic wip_in
);

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit, abort}));

  assert_pulse_once_R11: assert property (@(posedge clk) disable iff (rst)
    (commit || abort) |=> !(commit || abort));

  assert_commit_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(wel));

  assert_commit_no_wip_R4: assert property (@(posedge clk) disable iff (rst)
    commit |-> !$past(wip_in));

  assert_wel_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (commit || abort) |-> !wel);

endmodule

bind spi_wr_front spi_wr_front_chk u_chk (
  .clk(clk), .rst(rst), .commit(commit), .abort(abort),
  .wel(wel), .wip_in(wip_in)
);

// File: tb/sim_spi_wr_front.sv
`timescale 1ns/1ps
module sim_spi_wr_front;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, sck, mosi;
  logic        so, so_oe;
  logic        wel_set, bp_load, wip_in;
  logic [1:0]  bp_din;
  logic        byte_valid;
  logic [10:0] byte_addr;
  logic [7:0]  byte_data;
  logic        commit, abort, wel;
  logic [1:0]  bp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          nb, ncommit, nabort, noe;
  logic [10:0] cap_addr [64];
  logic [7:0]  cap_data [64];

  always #5 clk = ~clk;

  spi_wr_front u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .so(so), .so_oe(so_oe), .wel_set(wel_set), .bp_load(bp_load),
    .bp_din(bp_din), .wip_in(wip_in), .byte_valid(byte_valid),
    .byte_addr(byte_addr), .byte_data(byte_data), .commit(commit),
    .abort(abort), .wel(wel), .bp(bp)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        if (nb < 64) begin
          cap_addr[nb] = byte_addr;
          cap_data[nb] = byte_data;
        end
        nb++;
      end
      if (commit) ncommit++;
      if (abort)  nabort++;
      if (so_oe)  noe++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      #40 sck = 1'b1;
      #40 sck = 1'b0;
    end
  endtask

  task automatic pulse_wen();
    @(negedge clk) wel_set = 1'b1;
    @(negedge clk) wel_set = 1'b0;
  endtask

  task automatic load_bp(input logic [1:0] v);
    @(negedge clk) begin bp_load = 1'b1; bp_din = v; end
    @(negedge clk) bp_load = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] a,
                      input int nd, input int extra, input int seed);
    @(negedge clk);
    nb = 0; ncommit = 0; nabort = 0;
    cs_n = 1'b0;
    #80;
    spi_bits(op, 8);
    spi_bits(a[15:8], 8);
    spi_bits(a[7:0], 8);
    for (int i = 0; i < nd; i++) spi_bits(8'(seed + i * 37), 8);
    if (extra > 0) spi_bits(8'hA5, extra);
    #80 cs_n = 1'b1;
    #200;
  endtask

  task automatic verify(input string tag, input logic [7:0] op, input logic [15:0] a,
                        input int nd, input int extra, input int seed,
                        input bit wel0, input bit wip0, input logic [1:0] bp0);
    bit attempt, prot, acc;
    int pg;
    attempt = (op == 8'h02);
    pg = int'(a[10:5]);
    prot = (bp0 == 2'd3) || (bp0 == 2'd2 && pg >= 32) || (bp0 == 2'd1 && pg >= 48);
    acc = attempt && nd >= 1 && extra == 0 && wel0 && !wip0 && !prot;
    chk({tag, " R1/R8 byte count"}, nb, attempt ? nd : 0);
    if (attempt) begin
      for (int i = 0; i < nd && i < 64; i++) begin
        chk({tag, " R2/R7 addr"}, int'(cap_addr[i]),
            pg * 32 + ((int'(a[4:0]) + i) % 32));
        chk({tag, " R1 data"}, int'(cap_data[i]), (seed + i * 37) % 256);
      end
    end
    chk({tag, " commit"}, ncommit, acc ? 1 : 0);
    chk({tag, " R11 abort"}, nabort, (attempt && !acc) ? 1 : 0);
    chk({tag, " R9 wel after"}, int'(wel), attempt ? 0 : int'(wel0));
  endtask

  initial begin
    #1_800_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    wel_set = 1'b0; bp_load = 1'b0; bp_din = 2'b00; wip_in = 1'b0;
    nb = 0; ncommit = 0; nabort = 0; noe = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset wel", int'(wel), 0);
    chk("R12 reset bp", int'(bp), 0);
    chk("R11 reset commit", int'(commit), 0);
    chk("R10 reset so_oe", int'(so_oe), 0);

    // R1: single byte accepted
    pulse_wen();
    chk("R9 wel set", int'(wel), 1);
    xfer(8'h02, 16'h0123, 1, 0, 8'h5C);
    verify("R1 single", 8'h02, 16'h0123, 1, 0, 8'h5C, 1, 0, 2'b00);

    // R2: 35 bytes from offset 5 wrap in page
    pulse_wen();
    xfer(8'h02, 16'h0045, 35, 0, 8'h11);
    verify("R2 wrap", 8'h02, 16'h0045, 35, 0, 8'h11, 1, 0, 2'b00);

    // R3: no write enable
    xfer(8'h02, 16'h0200, 2, 0, 8'h20);
    verify("R3 no wel", 8'h02, 16'h0200, 2, 0, 8'h20, 0, 0, 2'b00);

    // R4: write in progress
    pulse_wen();
    wip_in = 1'b1;
    xfer(8'h02, 16'h0300, 1, 0, 8'h30);
    verify("R4 wip", 8'h02, 16'h0300, 1, 0, 8'h30, 1, 1, 2'b00);
    wip_in = 1'b0;

    // R6: chip select rise inside a data byte, for several bit counts
    for (int e = 1; e < 8; e += 3) begin
      pulse_wen();
      xfer(8'h02, 16'h0400, 1, e, 8'h40);
      verify("R6 partial", 8'h02, 16'h0400, 1, e, 8'h40, 1, 0, 2'b00);
    end

    // R6: no data byte at all
    pulse_wen();
    xfer(8'h02, 16'h0500, 0, 0, 8'h50);
    verify("R6 no data", 8'h02, 16'h0500, 0, 0, 8'h50, 1, 0, 2'b00);

    // R6: chip select rise inside the address
    pulse_wen();
    @(negedge clk);
    nb = 0; ncommit = 0; nabort = 0;
    cs_n = 1'b0;
    #80;
    spi_bits(8'h02, 8);
    spi_bits(8'h12, 8);
    spi_bits(8'h34, 3);
    #80 cs_n = 1'b1;
    #200;
    chk("R6 mid-address abort", nabort, 1);
    chk("R6 mid-address commit", ncommit, 0);
    chk("R6 mid-address bytes", nb, 0);
    chk("R9 mid-address wel", int'(wel), 0);

    // R8: other opcode ignored, latch kept
    pulse_wen();
    xfer(8'h03, 16'h0600, 2, 0, 8'h60);
    verify("R8 bad opcode", 8'h03, 16'h0600, 2, 0, 8'h60, 1, 0, 2'b00);
    xfer(8'h02, 16'h0600, 1, 0, 8'h61);
    verify("R8 follow-up", 8'h02, 16'h0600, 1, 0, 8'h61, 1, 0, 2'b00);

    // R7: upper address bits ignored under quarter protection
    load_bp(2'b01);
    pulse_wen();
    xfer(8'h02, 16'hF823, 1, 0, 8'h70);
    verify("R7 upper bits", 8'h02, 16'hF823, 1, 0, 8'h70, 1, 0, 2'b01);

    // R5/R12: all codes over all pages
    for (int c = 0; c < 4; c++) begin
      load_bp(2'(c));
      chk("R12 bp load", int'(bp), c);
      for (int p = 0; p < 64; p++) begin
        logic [15:0] a;
        a = {5'((p * 7 + c) % 32), 6'(p), 5'((p * 3) % 32)};
        pulse_wen();
        xfer(8'h02, a, 1, 0, p + c);
        verify("R5 sweep", 8'h02, a, 1, 0, p + c, 1, 0, 2'(c));
      end
    end

    chk("R10 so_oe never high", noe, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule